// File: doc/BRIEF.md
# Rotate-Subtract Dual Subcycle Random Generator

This block produces a stream of pseudo-random words from two small sub-generators that need no multiplier. Each half keeps one state word. Half X subtracts a left-rotated copy of its state from the state and rotates the difference. Half Y subtracts its state from a left-rotated copy of itself and rotates the difference. Each step needs only fixed wiring for the rotations, one subtractor per half and a final XOR, so both halves advance in one clock cycle.

A seed pulse loads fixed start values into both halves. Each half is then stepped a number of times taken from its own 16-bit field of the seed. Both halves are seeded at the same time, each with its own down-counter. After seeding, the block steps both halves once more and then offers `x ^ y` on a valid/ready output. Each accepted word advances both halves by one step. A width parameter of 32 or 64 picks the rotation amounts and start values.

The controller has four states. IDLE is entered from reset. SEED counts the halves down. PRIME makes the one extra step. RUN presents words. The transitions are:
- IDLE→SEED on an accepted seed pulse.
- SEED→PRIME when both counters are zero.
- PRIME→RUN unconditionally.
- RUN→SEED on a new seed pulse.

Top module: `rsub_dual_gen`

## Requirements
- R1: A synchronous reset, active high, clears both state words, so `out_data` reads 0. It also drives `busy` and `out_valid` low and leaves the block in IDLE.
- R2: In the 32-bit variant, one step of half X sets x to rotl(x − rotl(x,11), 27), modulo 2^32. In the 64-bit variant the rotations are 21 and 36.
- R3: In the 32-bit variant, one step of half Y sets y to rotl(rotl(y,21) − y, 20), modulo 2^32. In the 64-bit variant the rotations are 43 and 27.
- R4: An accepted seed pulse loads x = 542 and y = 5981 (981906 and 590009 in the 64-bit variant). It then steps X (seed[31:16] + 20) times and Y (seed[15:0] + 20) times.
- R5: A seed pulse is accepted only while `busy` is low. A pulse while `busy` is high has no effect on the resulting stream.
- R6: After an accepted pulse, `busy` is high for max(nX, nY) + 2 cycles, where nX and nY are the step counts from R4. `out_valid` is low during that time.
- R7: After seeding, both halves step once more. `out_data` is then x XOR y. Each cycle with `out_valid` and `out_ready` both high advances both halves by exactly one step.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: If a seed pulse and an output handshake fall in the same cycle, the reseed wins. The old stream does not advance, and the next word offered belongs to the new seed.
- R10: Stepped by itself from any state on its cycle, half X returns to that state after 2847384 steps. Half Y returns after 1435175 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Seed pulse |
| seed_value | input | 32 | Seed; the upper half sets the X count, the lower half the Y count |
| busy | output | 1 | High while seeding or priming |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | W | x XOR y |

## Verification
A reseed request and an output handshake can coincide while the block is in RUN. The bench holds `out_ready` high and raises `seed_load` on the same cycle. It then checks that `busy` rises and `out_valid` drops. It also checks that the first word after seeding matches the reference model seeded with the new value, not the old stream advanced by one. The other overlap is a seed pulse that arrives during seeding. The bench judges it by comparing the resulting word and the busy length against the first seed.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEED  = 2'd1,
        ST_PRIME = 2'd2,
        ST_RUN   = 2'd3
    } gen_state_t;
endpackage

// File: rtl/rsub_half.sv
module rsub_half #(
    parameter int W       = 32,
    parameter int ROT_A   = 11,
    parameter int ROT_B   = 27,
    parameter bit REVERSE = 1'b0,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] q
);
    localparam int RA = ROT_A % W;
    localparam int RB = ROT_B % W;

    logic [W-1:0] rot_a;
    logic [W-1:0] diff;
    logic [W-1:0] nxt;

    assign rot_a = (q << RA) | (q >> (W - RA));

    generate
        if (REVERSE) begin : g_rot_minus_state
            assign diff = rot_a - q;
        end else begin : g_state_minus_rot
            assign diff = q - rot_a;
        end
    endgenerate

    assign nxt = (diff << RB) | (diff >> (W - RB));

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= INIT;
        else if (adv)  q <= nxt;
    end

    // Without load or advance the state must stay put (R7, R8)
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(q));
endmodule

// File: rtl/rsub_seed_cnt.sv
module rsub_seed_cnt #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (dec && !done) cnt <= cnt - 1'b1;
    end

    // Each decrement removes exactly one step from the budget (R4)
    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && dec && !done) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rsub_dual_gen.sv
module rsub_dual_gen #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_load,
    input  logic [31:0]  seed_value,
    output logic         busy,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    import rsub_pkg::*;

    localparam int HALF_W = 16;
    localparam int CW     = HALF_W + 1;
    localparam int EXTRA  = 20;
    localparam bit WIDE   = (W == 64);
    localparam int X_RA   = WIDE ? 21 : 11;
    localparam int X_RB   = WIDE ? 36 : 27;
    localparam int Y_RA   = WIDE ? 43 : 21;
    localparam int Y_RB   = WIDE ? 27 : 20;
    localparam logic [W-1:0] X_INIT = WIDE ? W'(981906) : W'(542);
    localparam logic [W-1:0] Y_INIT = WIDE ? W'(590009) : W'(5981);

    gen_state_t state, state_nxt;

    logic          accept;
    logic          take;
    logic          x_done, y_done;
    logic          x_adv, y_adv;
    logic [W-1:0]  x_q, y_q;
    logic [CW-1:0] x_cnt_init, y_cnt_init;

    assign accept     = seed_load && !busy;
    assign take       = (state == ST_RUN) && out_ready && !seed_load;
    assign x_cnt_init = CW'(seed_value[31:16]) + CW'(EXTRA);
    assign y_cnt_init = CW'(seed_value[15:0])  + CW'(EXTRA);

    assign x_adv = ((state == ST_SEED) && !x_done) || (state == ST_PRIME) || take;
    assign y_adv = ((state == ST_SEED) && !y_done) || (state == ST_PRIME) || take;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (seed_load)        state_nxt = ST_SEED;
            ST_SEED:  if (x_done && y_done) state_nxt = ST_PRIME;
            ST_PRIME:                       state_nxt = ST_RUN;
            ST_RUN:   if (seed_load)        state_nxt = ST_SEED;
            default:                        state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        busy      = (state == ST_SEED) || (state == ST_PRIME);
        out_valid = (state == ST_RUN);
        out_data  = x_q ^ y_q;
    end

    rsub_seed_cnt #(.CW(CW)) u_x_cnt (
        .clk(clk), .rst(rst), .load(accept), .load_val(x_cnt_init),
        .dec(state == ST_SEED), .done(x_done)
    );

    rsub_seed_cnt #(.CW(CW)) u_y_cnt (
        .clk(clk), .rst(rst), .load(accept), .load_val(y_cnt_init),
        .dec(state == ST_SEED), .done(y_done)
    );

    rsub_half #(.W(W), .ROT_A(X_RA), .ROT_B(X_RB), .REVERSE(1'b0), .INIT(X_INIT)) u_half_x (
        .clk(clk), .rst(rst), .load(accept), .adv(x_adv), .q(x_q)
    );

    rsub_half #(.W(W), .ROT_A(Y_RA), .ROT_B(Y_RB), .REVERSE(1'b1), .INIT(Y_INIT)) u_half_y (
        .clk(clk), .rst(rst), .load(accept), .adv(y_adv), .q(y_q)
    );

    p_seed_start_r5: assert property (@(posedge clk) disable iff (rst)
        (seed_load && !busy) |=> busy);

    p_no_valid_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !out_valid);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !seed_load) |=> (out_valid && $stable(out_data)));

    p_reseed_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && seed_load) |=> (busy && !out_valid));
endmodule

// File: tb/rsub_dual_gen_tb.sv
module rsub_dual_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic        busy, out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 0;

    logic [31:0] mx, my;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsub_dual_gen #(.W(32)) u_dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] rl(input logic [31:0] v, input int r);
        return (v << r) | (v >> (32 - r));
    endfunction

    function automatic logic [31:0] ref_x(input logic [31:0] v);
        logic [31:0] d;
        d = v - rl(v, 11);
        return rl(d, 27);
    endfunction

    function automatic logic [31:0] ref_y(input logic [31:0] v);
        logic [31:0] d;
        d = rl(v, 21) - v;
        return rl(d, 20);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_seed(input logic [31:0] s);
        mx = 32'd542;
        my = 32'd5981;
        for (int i = 0; i < int'(s[31:16]) + 20; i++) mx = ref_x(mx);
        for (int i = 0; i < int'(s[15:0]) + 20; i++)  my = ref_y(my);
        mx = ref_x(mx);
        my = ref_y(my);
    endtask

    task automatic model_next();
        mx = ref_x(mx);
        my = ref_y(my);
    endtask

    function automatic int busy_len(input logic [31:0] s);
        int a, b;
        a = int'(s[31:16]) + 20;
        b = int'(s[15:0]) + 20;
        return ((a > b) ? a : b) + 2;
    endfunction

    task automatic pulse_seed(input logic [31:0] s);
        @(negedge clk);
        seed_value = s;
        seed_load  = 1'b1;
        @(negedge clk);
        seed_load  = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 valid", out_valid, 0);
        check("R1 data", out_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle stays quiet", {busy, out_valid}, 0);
    endtask

    task automatic t_seed_stream(input logic [31:0] s, input int words);
        int n;
        out_ready = 1'b0;
        pulse_seed(s);
        wait_idle(n);
        check("R6 busy length", n, busy_len(s));
        check("R6 valid after seed", out_valid, 1);
        model_seed(s);
        check("R4 R7 first word", out_data, mx ^ my);
        out_ready = 1'b1;
        for (int i = 0; i < words; i++) begin
            @(negedge clk);
            model_next();
            check("R2 R3 R7 stream word", out_data, mx ^ my);
        end
        out_ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_backpressure();
        logic [31:0] held;
        held = out_data;
        out_ready = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8 valid held", out_valid, 1);
            check("R8 data held", out_data, held);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        model_next();
        check("R7 single advance", out_data, mx ^ my);
    endtask

    task automatic t_ignore_busy();
        int n;
        logic [31:0] a;
        a = 32'h0003_0007;
        pulse_seed(a);
        repeat (3) @(negedge clk);
        seed_value = 32'h00FF_00FF;
        seed_load  = 1'b1;
        @(negedge clk);
        seed_load  = 1'b0;
        wait_idle(n);
        check("R5 busy length unchanged", n, busy_len(a) - 4);
        model_seed(a);
        check("R5 stream from first seed", out_data, mx ^ my);
    endtask

    task automatic t_collision();
        int n;
        logic [31:0] c;
        c = 32'h0002_0011;
        check("R9 precondition valid", out_valid, 1);
        seed_value = c;
        seed_load  = 1'b1;
        out_ready  = 1'b1;
        @(negedge clk);
        seed_load  = 1'b0;
        out_ready  = 1'b0;
        check("R9 busy after collision", busy, 1);
        check("R9 valid dropped", out_valid, 0);
        wait_idle(n);
        check("R9 busy length", n, busy_len(c));
        model_seed(c);
        check("R9 new seed stream", out_data, mx ^ my);
    endtask

    task automatic t_period();
        logic [31:0] s0, v;
        int k;
        s0 = 32'd542;
        for (int i = 0; i < 3000; i++) s0 = ref_x(s0);
        v = ref_x(s0);
        k = 1;
        while (v != s0 && k < 3000000) begin
            v = ref_x(v);
            k++;
        end
        check("R10 X period", k, 2847384);
        s0 = 32'd5981;
        for (int i = 0; i < 3000; i++) s0 = ref_y(s0);
        v = ref_y(s0);
        k = 1;
        while (v != s0 && k < 3000000) begin
            v = ref_y(v);
            k++;
        end
        check("R10 Y period", k, 1435175);
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_seed_stream(32'h0000_0000, 6);
        t_seed_stream(32'h0005_0100, 4);
        t_seed_stream(32'h0040_0001, 3);
        pulse_seed(32'h0001_0001);
        begin
            int n;
            wait_idle(n);
        end
        model_seed(32'h0001_0001);
        t_backpressure();
        t_ignore_busy();
        t_collision();
        t_period();
        finish_run();
    end
endmodule